// File: doc/BRIEF.md
# Multi-cycle programmable ROM controller

This block models a byte-wide nonvolatile memory that a device programmer can erase and rewrite many times. Its bus mode comes from the active-low chip enable, output enable and write enable, and from two high-voltage detect flags, one on the output-enable pin and one on address bit 9. With no high voltage present the block acts as a plain read-only memory. High voltage on output enable alone turns a write-enable pulse into a byte program. High voltage on both output enable and address bit 9 turns it into a whole-array erase. High voltage on address bit 9 alone during a read returns fixed identification codes.

All pins are sampled on the system clock. Program and erase pulses are timed by counting a one-cycle `tick` strobe while write enable is held low. Each operation has its own minimum count, set by a parameter. A pulse that ends early is dropped and recorded in a sticky error flag. The byte array lives inside the block. Read data is registered and paired with a drive-enable flag that tells the pad ring when to drive the bus.

Top module: `mcprom_ctrl`

## Requirements
- R1: After reset, `dout_en`, `busy` and `abort_err` are all 0.
- R2: When `ce_n`=0, `oe_n`=0, `we_n`=1, `oe_hv`=0, `a9_hv`=0 and `busy`=0 at a clock edge, `dout_en` is 1 and `dout` holds the stored byte at `addr` after that edge.
- R3: If `ce_n`=1 (standby) or `oe_n`=1 (output disabled) at a clock edge, `dout_en` is 0 after that edge.
- R4: With `ce_n`=0 and `oe_hv`=1 and `a9_hv`=0, a falling edge of `we_n` captures `addr` and `din`. If `we_n` stays low for at least PROG_TICKS ticks, the byte at the captured address is written when `we_n` rises.
- R5: A program stores the bitwise AND of the old byte and the new data, so programming can never turn a 0 bit into 1.
- R6: With `ce_n`=0, `oe_hv`=1 and `a9_hv`=1, a falling edge of `we_n` followed by at least ERASE_TICKS ticks sets every byte to FFh once `we_n` rises, whatever `addr` and `din` were. The block then goes back to idle.
- R7: With `ce_n`=0, `oe_n`=0, `we_n`=1, `a9_hv`=1, `oe_hv`=0, the output byte is 9Dh when addr[1:0]=00, 9Bh when addr[1:0]=01, and 00h when addr[1]=1. Address bits above bit 1 have no effect.
- R8: If `we_n` rises before the minimum tick count of a program or erase, the array stays unchanged and `abort_err` becomes 1 and stays 1 until reset.
- R9: `busy` is 1 from the clock edge that sees the falling edge of `we_n` until the operation has finished, including the erase sweep. While `busy` is 1, `dout_en` stays 0.
- R10: A falling edge of `we_n` with `oe_hv`=0 starts nothing: `busy` stays 0 and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timing strobe used to measure pulse length |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_hv | input | 1 | High voltage detected on the output-enable pin |
| a9_hv | input | 1 | High voltage detected on address bit 9 |
| addr | input | AW | Byte address |
| din | input | 8 | Program data |
| dout | output | 8 | Registered read or identification data |
| dout_en | output | 1 | Data bus drive enable; 0 means high impedance |
| busy | output | 1 | Program or erase in progress |
| abort_err | output | 1 | Sticky flag for a pulse that ended too early |

## Verification
The array is first brought to a known erased state. Directed programs of the same byte with A5h, 0Fh and FFh show that the stored value is an AND, not an overwrite. Pulses one tick short of each limit, next to pulses exactly at the limit, separate a commit from an abort, and a write-enable edge with no high voltage shows that a normal write is ignored. Random addresses, data and pulse lengths are compared against a shadow copy, so a wrong address capture or a corrupted neighbour shows up. Identification reads with high address bits set and cleared confirm that only the two low bits pick the code.

// File: rtl/mcprom_pkg.sv
package mcprom_pkg;

    typedef enum logic [2:0] {
        BUS_QUIET,
        BUS_READ,
        BUS_IDENT,
        BUS_PROG,
        BUS_ERASE
    } bus_mode_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PROG,
        OP_ERASE,
        OP_SWEEP
    } op_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic oe_hv;
        logic a9_hv;
    } ctl_pins_t;

    localparam logic [7:0] MAKER_ID  = 8'h9D;
    localparam logic [7:0] PART_ID   = 8'h9B;
    localparam logic [7:0] NO_ID     = 8'h00;
    localparam logic [7:0] BLANK     = 8'hFF;

    function automatic bus_mode_e decode_bus(input ctl_pins_t p);
        bus_mode_e m;
        if (p.ce_n)
            m = BUS_QUIET;
        else if (p.oe_hv && p.a9_hv)
            m = BUS_ERASE;
        else if (p.oe_hv)
            m = BUS_PROG;
        else if (!p.oe_n && p.we_n)
            m = p.a9_hv ? BUS_IDENT : BUS_READ;
        else
            m = BUS_QUIET;
        return m;
    endfunction

    function automatic logic [7:0] ident_byte(input logic [1:0] sel);
        logic [7:0] v;
        case (sel)
            2'b00:   v = MAKER_ID;
            2'b01:   v = PART_ID;
            default: v = NO_ID;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mcprom_decode.sv
module mcprom_decode
    import mcprom_pkg::*;
(
    input  ctl_pins_t pins,
    output bus_mode_e mode
);
    always_comb begin
        mode = decode_bus(pins);
    end
endmodule

// File: rtl/mcprom_array.sv
module mcprom_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr_bus,
    output logic [7:0]    rd_data_bus,
    input  logic [AW-1:0] rd_addr_mod,
    output logic [7:0]    rd_data_mod
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    assign rd_data_bus = cells[rd_addr_bus];
    assign rd_data_mod = cells[rd_addr_mod];
endmodule

// File: rtl/mcprom_seq.sv
module mcprom_seq
    import mcprom_pkg::*;
#(
    parameter int AW          = 10,
    parameter int PROG_TICKS  = 20,
    parameter int ERASE_TICKS = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          we_n,
    input  bus_mode_e     mode,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output op_state_e     state,
    output logic          wr_en,
    output logic          wr_blank,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    cap_data,
    output logic          abort
);
    localparam int MAX_TICKS = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] PROG_LIM  = CW'(PROG_TICKS);
    localparam logic [CW-1:0] ERASE_LIM = CW'(ERASE_TICKS);
    localparam logic [AW-1:0] LAST_IDX  = {AW{1'b1}};

    logic          we_q;
    logic          we_fall;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [AW-1:0] cap_addr;
    logic [AW-1:0] sweep_idx;
    logic          in_pulse;
    logic          pulse_end;
    logic          long_enough;

    assign we_fall     = we_q && !we_n;
    assign in_pulse    = (state == OP_PROG) || (state == OP_ERASE);
    assign limit       = (state == OP_ERASE) ? ERASE_LIM : PROG_LIM;
    assign long_enough = (cnt >= limit);
    assign pulse_end   = in_pulse && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= OP_IDLE;
            we_q      <= 1'b1;
            cnt       <= '0;
            cap_addr  <= '0;
            cap_data  <= '0;
            sweep_idx <= '0;
        end else begin
            we_q <= we_n;
            unique case (state)
                OP_IDLE: begin
                    if (we_fall && mode == BUS_PROG) begin
                        state    <= OP_PROG;
                        cnt      <= '0;
                        cap_addr <= addr;
                        cap_data <= din;
                    end else if (we_fall && mode == BUS_ERASE) begin
                        state <= OP_ERASE;
                        cnt   <= '0;
                    end
                end
                OP_PROG, OP_ERASE: begin
                    if (we_n) begin
                        sweep_idx <= '0;
                        if (long_enough && state == OP_ERASE)
                            state <= OP_SWEEP;
                        else
                            state <= OP_IDLE;
                    end else if (tick && !long_enough) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                OP_SWEEP: begin
                    sweep_idx <= sweep_idx + 1'b1;
                    if (sweep_idx == LAST_IDX)
                        state <= OP_IDLE;
                end
                default: state <= OP_IDLE;
            endcase
        end
    end

    assign wr_en    = (state == OP_SWEEP) || (state == OP_PROG && pulse_end && long_enough);
    assign wr_blank = (state == OP_SWEEP);
    assign wr_addr  = (state == OP_SWEEP) ? sweep_idx : cap_addr;
    assign abort    = pulse_end && !long_enough;
endmodule

// File: rtl/mcprom_ctrl.sv
module mcprom_ctrl
    import mcprom_pkg::*;
#(
    parameter int AW          = 10,
    parameter int PROG_TICKS  = 20,
    parameter int ERASE_TICKS = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          oe_hv,
    input  logic          a9_hv,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en,
    output logic          busy,
    output logic          abort_err
);
    ctl_pins_t     pins;
    bus_mode_e     mode;
    op_state_e     state;
    logic          wr_en;
    logic          wr_blank;
    logic [AW-1:0] wr_addr;
    logic [7:0]    cap_data;
    logic          abort;
    logic [7:0]    bus_byte;
    logic [7:0]    old_byte;
    logic [7:0]    new_byte;
    logic          drive_next;

    assign pins = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, oe_hv: oe_hv, a9_hv: a9_hv};

    mcprom_decode u_decode (
        .pins (pins),
        .mode (mode)
    );

    mcprom_seq #(
        .AW          (AW),
        .PROG_TICKS  (PROG_TICKS),
        .ERASE_TICKS (ERASE_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .we_n     (we_n),
        .mode     (mode),
        .addr     (addr),
        .din      (din),
        .state    (state),
        .wr_en    (wr_en),
        .wr_blank (wr_blank),
        .wr_addr  (wr_addr),
        .cap_data (cap_data),
        .abort    (abort)
    );

    assign new_byte = wr_blank ? BLANK : (old_byte & cap_data);

    mcprom_array #(
        .AW (AW)
    ) u_array (
        .clk         (clk),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (new_byte),
        .rd_addr_bus (addr),
        .rd_data_bus (bus_byte),
        .rd_addr_mod (wr_addr),
        .rd_data_mod (old_byte)
    );

    assign busy       = (state != OP_IDLE);
    assign drive_next = ((mode == BUS_READ) || (mode == BUS_IDENT)) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout      <= '0;
            dout_en   <= 1'b0;
            abort_err <= 1'b0;
        end else begin
            dout_en   <= drive_next;
            dout      <= (mode == BUS_IDENT) ? ident_byte(addr[1:0]) : bus_byte;
            abort_err <= abort_err | abort;
        end
    end
endmodule

// File: rtl/mcprom_chk.sv
module mcprom_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          oe_hv,
    input logic          a9_hv,
    input logic [AW-1:0] addr,
    input logic [7:0]    dout,
    input logic          dout_en,
    input logic          busy,
    input logic          abort_err
);
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !dout_en) else $error("standby drove bus"); // R3

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !dout_en) else $error("output disable drove bus"); // R3

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |=> !dout_en) else $error("bus driven while busy"); // R9

    AST_MAKER_CODE: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && we_n && a9_hv && !oe_hv && !busy && addr[1:0] == 2'b00)
        |=> (dout_en && dout == 8'h9D)) else $error("maker code wrong"); // R7

    AST_PART_CODE: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && we_n && a9_hv && !oe_hv && !busy && addr[1:0] == 2'b01)
        |=> (dout_en && dout == 8'h9B)) else $error("part code wrong"); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        abort_err |=> abort_err) else $error("error flag cleared"); // R8

    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($fell(we_n) && !ce_n && oe_hv && !busy) |=> busy) else $error("pulse not busy"); // R9

    AST_PLAIN_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(we_n) && !oe_hv && !busy) |=> !busy) else $error("plain write started op"); // R10
endmodule

bind mcprom_ctrl mcprom_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .oe_hv     (oe_hv),
    .a9_hv     (a9_hv),
    .addr      (addr),
    .dout      (dout),
    .dout_en   (dout_en),
    .busy      (busy),
    .abort_err (abort_err)
);

// File: tb/mcprom_ctrl_bench.sv
module mcprom_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int DEPTH      = 1 << AW;
    localparam int PT         = 20;
    localparam int ET         = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_hv = 1'b0;
    logic          a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;
    logic          busy;
    logic          abort_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;
    logic [7:0] shadow [DEPTH];
    logic [AW-1:0] used [40];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcprom_ctrl #(.AW(AW), .PROG_TICKS(PT), .ERASE_TICKS(ET)) u_mcprom_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .busy(busy), .abort_err(abort_err)
    );

    function automatic logic [7:0] exp_ident(input logic [AW-1:0] a);
        if (a[1]) return 8'h00;
        return a[0] ? 8'h9B : 8'h9D;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_byte(input logic [AW-1:0] a, input bit ident,
                             output logic [7:0] d, output logic en);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; oe_hv = 0; a9_hv = ident; addr = a;
        @(negedge clk);
        d = dout; en = dout_en;
        ce_n = 1; oe_n = 1; a9_hv = 0;
    endtask

    task automatic check_read(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        read_byte(a, 0, d, en);
        check(req, {7'b0, en}, 8'd1);
        check(req, d, exp);
    endtask

    task automatic pulse(input bit erase, input logic [AW-1:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        ce_n = 0; oe_n = 1; oe_hv = 1; a9_hv = erase; addr = a; din = d;
        @(negedge clk);
        we_n = 0;
        @(negedge clk);
        check("R9 busy at pulse", {7'b0, busy}, 8'd1);
        for (int i = 0; i < n; i++) begin
            tick = 1;
            @(negedge clk);
            tick = 0;
        end
        we_n = 1;
        @(negedge clk);
        oe_hv = 0; a9_hv = 0;
        if (erase && n >= ET) begin
            ce_n = 0; oe_n = 0;
            @(negedge clk);
            check("R9 busy in sweep", {7'b0, busy}, 8'd1);
            check("R9 quiet in sweep", {7'b0, dout_en}, 8'd0);
            oe_n = 1;
        end
        ce_n = 1;
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        if (erase && n >= ET) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        end else if (!erase && n >= PT) begin
            shadow[a] = shadow[a] & d;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic en;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 dout_en", {7'b0, dout_en}, 8'd0);
        check("R1 busy", {7'b0, busy}, 8'd0);
        check("R1 abort_err", {7'b0, abort_err}, 8'd0);

        // R6: erase with junk address and data
        pulse(1, 10'h3A5, 8'h12, ET);
        check("R6 idle after erase", {7'b0, busy}, 8'd0);
        check_read("R6 R2 first", 10'h000, 8'hFF);
        check_read("R6 R2 last", 10'h3FF, 8'hFF);
        check_read("R6 junk addr", 10'h3A5, 8'hFF);
        check("R8 no error yet", {7'b0, abort_err}, 8'd0);

        // R4 / R5 AND behaviour
        pulse(0, 10'h005, 8'hA5, PT);
        check_read("R4 program", 10'h005, 8'hA5);
        check_read("R4 neighbour", 10'h004, 8'hFF);
        pulse(0, 10'h005, 8'h0F, PT + 3);
        check_read("R5 and", 10'h005, 8'h05);
        pulse(0, 10'h005, 8'hFF, PT);
        check_read("R5 no set", 10'h005, 8'h05);

        // R8 short program
        pulse(0, 10'h006, 8'h00, PT - 1);
        check_read("R8 prog unchanged", 10'h006, 8'hFF);
        check("R8 flag", {7'b0, abort_err}, 8'd1);

        // R10 plain write enable edge
        @(negedge clk);
        ce_n = 0; oe_n = 1; oe_hv = 0; addr = 10'h005; din = 8'h00;
        @(negedge clk);
        we_n = 0;
        @(negedge clk);
        check("R10 not busy", {7'b0, busy}, 8'd0);
        repeat (PT + 2) begin tick = 1; @(negedge clk); tick = 0; end
        we_n = 1; ce_n = 1;
        @(negedge clk);
        check("R10 not busy after", {7'b0, busy}, 8'd0);
        check_read("R10 unchanged", 10'h005, 8'h05);

        // R7 identification
        read_byte(10'h000, 1, d, en);
        check("R7 maker", d, exp_ident(10'h000));
        read_byte(10'h001, 1, d, en);
        check("R7 part", d, exp_ident(10'h001));
        read_byte(10'h3FC, 1, d, en);
        check("R7 high bits ignored", d, exp_ident(10'h3FC));
        read_byte(10'h2FD, 1, d, en);
        check("R7 high bits ignored part", d, exp_ident(10'h2FD));
        read_byte(10'h002, 1, d, en);
        check("R7 other", d, exp_ident(10'h002));
        check("R7 drive", {7'b0, en}, 8'd1);

        // R3 standby and output disable
        @(negedge clk);
        ce_n = 1; oe_n = 0; we_n = 1; addr = 10'h005;
        @(negedge clk);
        check("R3 standby", {7'b0, dout_en}, 8'd0);
        ce_n = 0; oe_n = 1;
        @(negedge clk);
        check("R3 disable", {7'b0, dout_en}, 8'd0);
        ce_n = 1;

        // random programs against shadow
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] ra;
            logic [7:0] rd;
            int n;
            ra = AW'($urandom_range(0, DEPTH - 1));
            rd = 8'($urandom);
            n  = ($urandom_range(0, 3) == 0) ? $urandom_range(1, PT - 1) : $urandom_range(PT, PT + 6);
            used[k] = ra;
            pulse(0, ra, rd, n);
        end
        for (int k = 0; k < 40; k++) check_read("R4 R5 random", used[k], shadow[used[k]]);
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom_range(0, DEPTH - 1));
            check_read("R2 random", ra, shadow[ra]);
        end

        // R8 short erase leaves array alone
        pulse(1, 10'h000, 8'h00, ET / 2);
        for (int k = 0; k < 10; k++) check_read("R8 erase unchanged", used[k], shadow[used[k]]);

        // full erase again
        pulse(1, 10'h111, 8'h00, ET + 4);
        for (int k = 0; k < 10; k++) check_read("R6 re-erase", used[k], 8'hFF);
        check("R8 still set", {7'b0, abort_err}, 8'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule